// File: doc/BRIEF.md
# I2C Slave Byte Engine with Four-Way Bus Selector

This block is the target side of an I2C link. A 2-bit select picks one of four external SCL/SDA pairs and routes it into a single engine. The engine watches the chosen pair for START and STOP conditions. After a START it shifts in the address byte and compares the upper seven bits with a programmable own address. When general-call recognition is enabled, it also accepts the all-zero address. On a match it acknowledges. It then either receives data bytes into a holding register or sends bytes taken from a host-written buffer, depending on the direction bit of the address byte.

The host side is register-like. The host writes a transmit byte with a one-cycle load strobe. It takes a received byte and clears the received flag with a one-cycle read strobe. Status flags show the progress of the transfer. SDA is only ever pulled low: the engine presents one drive-low enable per bus, and only the selected bus's enable can be active. The engine samples both lines in its own clock domain through a synchroniser, so the system clock must run well above the SCL rate (at least ten times in practice). It does not stretch the clock and does not filter glitches.

Top module: `i2cSlaveHub`

## Requirements
- R1: Only the SCL/SDA pair chosen by `busSel` reaches the engine. Bit `i` of `sdaDriveLow` can be 1 only while `busSel == i`, and other buses never see a drive.
- R2: After reset the engine is an idle slave. All `sdaDriveLow` bits are 0, all status flags are 0 and `rxData` is 0.
- R3: Bytes are taken most significant bit first. The first byte after a START is the address, and its bits 7..1 are compared with `ownAddr`. On a nonzero match, SDA is pulled low during the ninth SCL pulse and `addrMatch` is set. On a mismatch, SDA stays released until the next START or STOP.
- R4: An address field of 0 is accepted only while `gcEnable` is 1. In that case it is acknowledged and `gcSeen` is set, while `addrMatch` stays 0. With `gcEnable` at 0, an address field of 0 is not acknowledged.
- R5: When address bit 0 is 0, each following byte is received MSB first. After its eighth bit it appears on `rxData` with `rxFull` set, and it is acknowledged on the ninth pulse. A `rxRead` pulse clears `rxFull`.
- R6: When address bit 0 is 1, `slaveTx` is set and the engine sends the byte held from the last `txLoad`, MSB first, with bit value 0 driven as low. `txReq` is set each time a byte moves from the buffer into the shifter, and a `txLoad` pulse clears it.
- R7: While `ackEnable` is 0, SDA is left released on the ninth pulse, both after the address and after received data bytes.
- R8: In transmit, if the master leaves SDA high on the ninth pulse (not-acknowledge), the engine releases SDA and stays released until the next START or STOP.
- R9: A STOP (SDA rising while SCL is high) returns the engine to idle and sets `stopSeen`. A START (SDA falling while SCL is high) clears `stopSeen`, `addrMatch` and `gcSeen`.
- R10: The engine's drive on SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 2 | Which of the four buses is connected |
| sclIn | input | 4 | SCL line level of each bus |
| sdaIn | input | 4 | SDA line level of each bus |
| sdaDriveLow | output | 4 | Open-drain pull-low enable per bus |
| ownAddr | input | 7 | Own 7-bit slave address |
| gcEnable | input | 1 | Accept the general-call address |
| ackEnable | input | 1 | Drive acknowledge on the ninth pulse |
| txData | input | 8 | Byte to transmit |
| txLoad | input | 1 | Load `txData` into the transmit buffer, clear `txReq` |
| rxRead | input | 1 | Host took `rxData`, clear `rxFull` |
| rxData | output | 8 | Last received data byte |
| slaveTx | output | 1 | Direction of the current transfer (1 = slave sends) |
| addrMatch | output | 1 | Own address recognised since the last START |
| gcSeen | output | 1 | General call recognised since the last START |
| rxFull | output | 1 | A received byte waits in `rxData` |
| txReq | output | 1 | Transmit buffer consumed, next byte wanted |
| stopSeen | output | 1 | STOP seen since the last START |

## Verification
The assertions take for granted a well-behaved master. It changes SDA only while SCL is low, except to form START and STOP. It never issues a START or STOP while the engine pulls SDA low. Each SCL phase lasts several system clocks, so the synchronised view sees every edge. `busSel` changes only while all buses are idle. The bench's master model keeps to this: SCL phases of ten clocks, data changes five clocks into the low phase, STOP only after a released ninth pulse, and bus switching only between transactions. Within these limits, the bench sweeps every address value and every data byte value.

// File: rtl/slvPkg.sv
package slvPkg;

  typedef enum logic [2:0] {
    sIdle,
    sAddr,
    sAddrAck,
    sRx,
    sRxAck,
    sTx,
    sTxAck,
    sWait
  } slvState_t;

  // control -> datapath
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic countBit;
    logic loadTx;
    logic clrCnt;
    logic captureRx;
    logic setMatch;
    logic setGc;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic sclRise;
    logic sclFall;
    logic sclS;
    logic sdaS;
    logic cntFull;
    logic ownHit;
    logic gcHit;
    logic rwBit;
    logic txMsb;
  } busEvt_t;

endpackage

// File: rtl/slvDatapath.sv
module slvDatapath
  import slvPkg::*;
#(
  parameter int NUM_BUS     = 4,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   busSel,
  input  logic [NUM_BUS-1:0] sclIn,
  input  logic [NUM_BUS-1:0] sdaIn,
  input  logic [ADDR_W-1:0]  ownAddr,
  input  logic               gcEnable,
  input  logic [DATA_W-1:0]  txData,
  input  logic               txLoad,
  input  logic               rxRead,
  input  ctlStrobe_t         strobe,
  output busEvt_t            evt,
  output logic [DATA_W-1:0]  rxData,
  output logic               addrMatch,
  output logic               gcSeen,
  output logic               rxFull,
  output logic               txReq,
  output logic               stopSeen
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  // One synchroniser chain behind the bus multiplexer
  logic sclMux, sdaMux;
  assign sclMux = sclIn[busSel];
  assign sdaMux = sdaIn[busSel];

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclMux};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaMux};
      sclPrev <= sclSync[SYNC_STAGES-1];
      sdaPrev <= sdaSync[SYNC_STAGES-1];
    end
  end

  logic sclNow, sdaNow;
  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  // Shared shifter and bit counter
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] txBuf;
  logic [CNT_W-1:0]  bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.shiftIn) begin
      shiftReg <= {shiftReg[DATA_W-2:0], sdaNow};
    end else if (strobe.loadTx) begin
      shiftReg <= txBuf;
    end else if (strobe.shiftOut) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strobe.clrCnt) begin
      bitCnt <= '0;
    end else if (strobe.countBit && bitCnt != CNT_FULL) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  logic [ADDR_W-1:0] addrField;
  assign addrField = shiftReg[DATA_W-1 -: ADDR_W];

  always_comb begin
    evt.startEv = sclNow && sclPrev && sdaPrev && !sdaNow;
    evt.stopEv  = sclNow && sclPrev && !sdaPrev && sdaNow;
    evt.sclRise = sclNow && !sclPrev;
    evt.sclFall = !sclNow && sclPrev;
    evt.sclS    = sclNow;
    evt.sdaS    = sdaNow;
    evt.cntFull = (bitCnt == CNT_FULL);
    evt.ownHit  = (addrField == ownAddr) && (addrField != '0);
    evt.gcHit   = (addrField == '0) && gcEnable;
    evt.rwBit   = shiftReg[0];
    evt.txMsb   = shiftReg[DATA_W-1];
  end

  // Host buffers and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf  <= '0;
      rxData <= '0;
      rxFull <= 1'b0;
      txReq  <= 1'b0;
    end else begin
      if (txLoad) txBuf <= txData;
      if (strobe.captureRx) rxData <= shiftReg;
      if (strobe.captureRx) rxFull <= 1'b1;
      else if (rxRead)      rxFull <= 1'b0;
      if (strobe.loadTx)    txReq <= 1'b1;
      else if (txLoad)      txReq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrMatch <= 1'b0;
      gcSeen    <= 1'b0;
      stopSeen  <= 1'b0;
    end else if (evt.startEv) begin
      addrMatch <= 1'b0;
      gcSeen    <= 1'b0;
      stopSeen  <= 1'b0;
    end else begin
      if (strobe.setMatch) addrMatch <= 1'b1;
      if (strobe.setGc)    gcSeen    <= 1'b1;
      if (evt.stopEv)      stopSeen  <= 1'b1;
    end
  end

  // R5: the bit counter never passes one byte
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_FULL);

  // R5: a captured byte is the shifter content and raises rxFull
  a_r5_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureRx |=> (rxFull && rxData == $past(shiftReg)));

  // R9: a STOP raises stopSeen
  a_r9_stop_flag: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopEv |=> stopSeen);

endmodule

// File: rtl/slvControl.sv
module slvControl
  import slvPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busEvt_t    evt,
  input  logic       ackEnable,
  output ctlStrobe_t strobe,
  output logic       drvLow,
  output logic       slaveTx
);

  slvState_t state, nextState;
  logic ackOn, masterAck;
  logic enterAck;

  always_comb begin
    nextState = state;
    strobe    = '0;
    enterAck  = 1'b0;
    if (evt.stopEv) begin
      nextState = sIdle;
    end else if (evt.startEv) begin
      nextState     = sAddr;
      strobe.clrCnt = 1'b1;
    end else begin
      unique case (state)
        sAddr: begin
          if (evt.sclRise && !evt.cntFull) begin
            strobe.shiftIn  = 1'b1;
            strobe.countBit = 1'b1;
          end else if (evt.sclFall && evt.cntFull) begin
            if (evt.ownHit || evt.gcHit) begin
              nextState       = sAddrAck;
              enterAck        = 1'b1;
              strobe.setMatch = evt.ownHit;
              strobe.setGc    = evt.gcHit;
            end else begin
              nextState = sWait;
            end
          end
        end
        sAddrAck: begin
          if (evt.sclFall) begin
            strobe.clrCnt = 1'b1;
            if (slaveTx) begin
              nextState     = sTx;
              strobe.loadTx = 1'b1;
            end else begin
              nextState = sRx;
            end
          end
        end
        sRx: begin
          if (evt.sclRise && !evt.cntFull) begin
            strobe.shiftIn  = 1'b1;
            strobe.countBit = 1'b1;
          end else if (evt.sclFall && evt.cntFull) begin
            strobe.captureRx = 1'b1;
            nextState        = sRxAck;
            enterAck         = 1'b1;
          end
        end
        sRxAck: begin
          if (evt.sclFall) begin
            strobe.clrCnt = 1'b1;
            nextState     = sRx;
          end
        end
        sTx: begin
          if (evt.sclRise) begin
            strobe.countBit = 1'b1;
          end else if (evt.sclFall) begin
            if (evt.cntFull) nextState = sTxAck;
            else             strobe.shiftOut = 1'b1;
          end
        end
        sTxAck: begin
          if (evt.sclFall) begin
            if (masterAck) begin
              nextState     = sTx;
              strobe.loadTx = 1'b1;
              strobe.clrCnt = 1'b1;
            end else begin
              nextState = sWait;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= sIdle;
      slaveTx   <= 1'b0;
      ackOn     <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state <= nextState;
      if (evt.startEv) slaveTx <= 1'b0;
      else if (strobe.setMatch || strobe.setGc) slaveTx <= evt.rwBit;
      if (enterAck) ackOn <= ackEnable;
      if (state == sTxAck && evt.sclRise) masterAck <= !evt.sdaS;
    end
  end

  always_comb begin
    unique case (state)
      sAddrAck, sRxAck: drvLow = ackOn;
      sTx:              drvLow = !evt.txMsb;
      default:          drvLow = 1'b0;
    endcase
  end

  // R2: an idle engine leaves SDA released
  a_r2_idle_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == sIdle) |-> !drvLow);

  // R10: the drive only moves while the synchronised SCL is low
  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(drvLow) |-> !evt.sclS);

  // R7: acknowledge suppressed for a received byte when disabled
  a_r7_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    (state == sRx && evt.sclFall && evt.cntFull && !evt.stopEv && !evt.startEv && !ackEnable)
      |=> !drvLow);

  // R8: a not-acknowledge in transmit releases the bus
  a_r8_nack_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == sTxAck && evt.sclFall && !masterAck && !evt.stopEv && !evt.startEv)
      |=> (state == sWait && !drvLow));

  // R9: a STOP always returns to idle
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopEv |=> (state == sIdle));

endmodule

// File: rtl/i2cSlaveHub.sv
module i2cSlaveHub
  import slvPkg::*;
#(
  parameter int NUM_BUS     = 4,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   busSel,
  input  logic [NUM_BUS-1:0] sclIn,
  input  logic [NUM_BUS-1:0] sdaIn,
  output logic [NUM_BUS-1:0] sdaDriveLow,
  input  logic [ADDR_W-1:0]  ownAddr,
  input  logic               gcEnable,
  input  logic               ackEnable,
  input  logic [DATA_W-1:0]  txData,
  input  logic               txLoad,
  input  logic               rxRead,
  output logic [DATA_W-1:0]  rxData,
  output logic               slaveTx,
  output logic               addrMatch,
  output logic               gcSeen,
  output logic               rxFull,
  output logic               txReq,
  output logic               stopSeen
);

  ctlStrobe_t strobe;
  busEvt_t    evt;
  logic       drvLow;

  slvDatapath #(
    .NUM_BUS(NUM_BUS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .busSel(busSel), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .gcEnable(gcEnable), .txData(txData), .txLoad(txLoad),
    .rxRead(rxRead), .strobe(strobe), .evt(evt), .rxData(rxData),
    .addrMatch(addrMatch), .gcSeen(gcSeen), .rxFull(rxFull), .txReq(txReq),
    .stopSeen(stopSeen)
  );

  slvControl uControl (
    .clk(clk), .rstN(rstN), .evt(evt), .ackEnable(ackEnable),
    .strobe(strobe), .drvLow(drvLow), .slaveTx(slaveTx)
  );

  // Demultiplex the single pull-low enable back to the selected bus
  for (genvar i = 0; i < NUM_BUS; i++) begin : gDrive
    assign sdaDriveLow[i] = drvLow && (busSel == SEL_W'(i));
  end

  // R1: at most one bus is pulled, and only the selected one
  a_r1_selected_only: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sdaDriveLow) && ((sdaDriveLow & ~(NUM_BUS'(1) << busSel)) == '0));

endmodule

// File: tb/i2cSlaveHub_test.sv
module i2cSlaveHub_test;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam int H = 10;
  localparam logic [6:0] OWN = 7'h5A;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0] curBus = 2'd0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic [3:0] sclIn, sdaIn, sdaDriveLow;
  logic [6:0] ownAddr = OWN;
  logic gcEnable = 1'b0, ackEnable = 1'b1;
  logic [7:0] txData = 8'h00;
  logic txLoad = 1'b0, rxRead = 1'b0;
  logic [7:0] rxData;
  logic slaveTx, addrMatch, gcSeen, rxFull, txReq, stopSeen;

  logic sdaLine;
  assign sdaLine = mSda & ~sdaDriveLow[curBus];
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      sclIn[i] = (curBus == 2'(i)) ? mScl : 1'b1;
      sdaIn[i] = (curBus == 2'(i)) ? sdaLine : 1'b1;
    end
  end

  i2cSlaveHub uut (
    .clk(clk), .rstN(rstN), .busSel(curBus), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaDriveLow(sdaDriveLow), .ownAddr(ownAddr), .gcEnable(gcEnable),
    .ackEnable(ackEnable), .txData(txData), .txLoad(txLoad), .rxRead(rxRead),
    .rxData(rxData), .slaveTx(slaveTx), .addrMatch(addrMatch), .gcSeen(gcSeen),
    .rxFull(rxFull), .txReq(txReq), .stopSeen(stopSeen)
  );

  int checks = 0;
  int failures = 0;
  int otherBusDrives = 0;
  int drvMovesSclHigh = 0;
  logic [3:0] prevDrv = 4'b0;

  // Pin-level monitors for R1 and R10
  always @(negedge clk) begin
    if (rstN) begin
      if ((sdaDriveLow & ~(4'b0001 << curBus)) != 4'b0) otherBusDrives++;
      if (sdaDriveLow != prevDrv && mScl) drvMovesSclHigh++;
    end
    prevDrv = sdaDriveLow;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b0; tick(Q);
    mScl = 1'b0;
  endtask

  task automatic stopCond();
    tick(Q); mSda = 1'b0;
    tick(Q); mScl = 1'b1;
    tick(Q); mSda = 1'b1;
    tick(H);
  endtask

  task automatic sendBit(input logic b);
    tick(Q); mSda = b;
    tick(Q); mScl = 1'b1;
    tick(H); mScl = 1'b0;
  endtask

  task automatic readBit(output logic b);
    tick(Q); mSda = 1'b1;
    tick(Q); mScl = 1'b1;
    tick(Q); b = sdaLine;
    tick(Q); mScl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic a;
    for (int k = 7; k >= 0; k--) sendBit(v[k]);
    readBit(a);
    acked = !a;
  endtask

  task automatic readByte(output logic [7:0] v);
    logic b;
    v = 8'h00;
    for (int k = 0; k < 8; k++) begin
      readBit(b);
      v = {v[6:0], b};
    end
  endtask

  task automatic hostPulse(input bit isLoad, input logic [7:0] v);
    @(negedge clk);
    if (isLoad) begin txData = v; txLoad = 1'b1; end
    else rxRead = 1'b1;
    @(negedge clk);
    txLoad = 1'b0; rxRead = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic acked;
    logic [7:0] got;
    tick(4);
    rstN = 1'b1;
    tick(4);

    // R2 reset state
    check(sdaDriveLow == 4'b0, "R2 drive after reset", sdaDriveLow, 0);
    check({addrMatch, gcSeen, rxFull, txReq, stopSeen, slaveTx} == 6'b0,
          "R2 flags after reset", {addrMatch, gcSeen, rxFull, txReq, stopSeen, slaveTx}, 0);
    check(rxData == 8'h00, "R2 rxData after reset", rxData, 0);

    // R3/R4 sweep of every address (write direction), rotating bus
    for (int a = 0; a < 128; a++) begin
      curBus = 2'(a % 4);
      tick(4);
      startCond();
      sendByte({7'(a), 1'b0}, acked);
      check(acked == (a == int'(OWN)), (a == 0) ? "R4 gc disabled" : "R3 address ack",
            acked, (a == int'(OWN)));
      check(addrMatch == (a == int'(OWN)), "R3 addrMatch flag", addrMatch, (a == int'(OWN)));
      stopCond();
    end

    // R9 stop flag and clearing by START
    check(stopSeen == 1'b1, "R9 stopSeen after STOP", stopSeen, 1);

    // R4 general call enabled
    gcEnable = 1'b1;
    curBus = 2'd1; tick(4);
    startCond();
    check(stopSeen == 1'b0, "R9 stopSeen cleared by START", stopSeen, 0);
    sendByte(8'h00, acked);
    check(acked, "R4 gc ack", acked, 1);
    check(gcSeen && !addrMatch, "R4 gcSeen flag", {gcSeen, addrMatch}, 2'b10);
    stopCond();
    gcEnable = 1'b0;

    // R5 receive every byte value
    curBus = 2'd2; tick(4);
    startCond();
    sendByte({OWN, 1'b0}, acked);
    check(acked && !slaveTx, "R5 write address ack", {acked, slaveTx}, 2'b10);
    for (int v = 0; v < 256; v++) begin
      sendByte(8'(v), acked);
      check(acked, "R5 data ack", acked, 1);
      check(rxData == 8'(v), "R5 rxData", rxData, v);
      check(rxFull, "R5 rxFull set", rxFull, 1);
      hostPulse(1'b0, 8'h00);
      check(!rxFull, "R5 rxFull cleared", rxFull, 0);
    end
    stopCond();

    // R7 acknowledge disabled
    ackEnable = 1'b0;
    curBus = 2'd3; tick(4);
    startCond();
    sendByte({OWN, 1'b0}, acked);
    check(!acked, "R7 address not acked", acked, 0);
    sendByte(8'h66, acked);
    check(!acked, "R7 data not acked", acked, 0);
    stopCond();
    ackEnable = 1'b1;

    // R6/R8 transmit
    curBus = 2'd0; tick(4);
    hostPulse(1'b1, 8'hC3);
    check(!txReq, "R6 txReq cleared by load", txReq, 0);
    startCond();
    sendByte({OWN, 1'b1}, acked);
    check(acked && slaveTx, "R6 read address ack", {acked, slaveTx}, 2'b11);
    readByte(got);
    check(got == 8'hC3, "R6 first byte", got, 8'hC3);
    check(txReq, "R6 txReq after byte taken", txReq, 1);
    hostPulse(1'b1, 8'h96);
    check(!txReq, "R6 txReq cleared", txReq, 0);
    sendBit(1'b0);
    readByte(got);
    check(got == 8'h96, "R6 second byte", got, 8'h96);
    sendBit(1'b1);
    readByte(got);
    check(got == 8'hFF, "R8 released after nack", got, 8'hFF);
    check(sdaDriveLow == 4'b0, "R8 no drive after nack", sdaDriveLow, 0);
    stopCond();
    check(stopSeen && sdaDriveLow == 4'b0, "R9 idle after STOP", {stopSeen, sdaDriveLow}, 5'h10);

    check(otherBusDrives == 0, "R1 unselected bus driven", otherBusDrives, 0);
    check(drvMovesSclHigh == 0, "R10 drive moved with SCL high", drvMovesSclHigh, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule